// File: doc/BRIEF.md
# One-Pulse Capture/Compare Timer

This block is a 16-bit up-counter timer with two input-capture channels and two output-compare channels. The counter advances on a prescaled tick taken either from the system clock (divided by 2, 4 or 8) or from the rising edges of an external clock pin. Each capture channel latches the counter on an active edge of its pin. Each compare channel raises a flag and can drive a programmed level onto its output when the counter reaches its compare value.

In one-pulse mode, an active edge on capture pin 0 restarts the counter at `16'hFFFC` and drives the "during" level on compare output 0. When the counter later reaches compare value 0, the output falls back to the "after" level. The pulse therefore lasts `((CMP0 - 16'hFFFC) mod 2^16) * N` system clocks, where N is the prescale divide. Software can also force a programmed level straight onto a compare output without raising any flag. The PWM-mode bit only takes priority over one-pulse mode and forcing; it generates no waveform of its own.

Software reaches the block through a single-cycle write port and a combinational read port. Register map (address: content):
- 0 CTRL_A: [0] ch0 edge, [1] ch1 edge (1 = rising, 0 = falling), [2] level L0, [3] level L1, [4] force ch0, [5] force ch1 (strobes, read as 0), [6] capture interrupt enable, [7] compare interrupt enable.
- 1 CTRL_B: [1:0] output enables, [2] one-pulse mode, [3] PWM mode, [5:4] clock select (0 = /2, 1 = /4, 2 = /8, 3 = external).
- 2 STATUS: [0] capture 0, [1] capture 1, [2] compare 0, [3] compare 1. Write 1 to clear.
- 3, 4 compare values 0 and 1.
- 5, 6 capture values 0 and 1, read-only.
- 7 counter, read-only.

Top module: `pulse_timer`

## Requirements
- R1: During reset the counter reads 0, and both compare outputs, all four flags and `irq` are 0.
- R2: With clock select 0, 1 or 2, the counter steps by exactly one every 2, 4 or 8 clocks. With select 3, it steps once per rising edge of `ext_clk` and holds otherwise.
- R3: Outside one-pulse mode, an active edge on `cap_in[i]`, as chosen by its CTRL_A edge bit, copies the counter into capture value i and sets capture flag i. The opposite edge does nothing.
- R4: Outside one-pulse and PWM mode, when the counter steps onto compare value i, compare flag i is set and compare output i takes level Li.
- R5: In one-pulse mode, an active edge on `cap_in[0]` loads the counter with `16'hFFFC` and capture value 0 with `16'hFFFD`, sets capture flag 0, and drives compare output 0 to L1 (the during level).
- R6: In one-pulse mode, compare output 0 switches to L0 (the after level) when the counter steps onto compare value 0, exactly `((CMP0 - 16'hFFFC) mod 65536) * N` clocks after the restart. Compare flag 0 is never set in this mode.
- R7: In one-pulse mode, a match on compare channel 1 still sets compare flag 1 but leaves compare output 1 unchanged.
- R8: In one-pulse mode with L0 equal to L1, compare output 0 stays at that level through the restart and the match.
- R9: With both the PWM and one-pulse bits set, an edge on `cap_in[0]` does not restart the counter and does not drive output 0. Instead it performs a normal capture of the running counter.
- R10: Writing CTRL_A with force bit i set, outside one-pulse and PWM mode, drives compare output i to the written level bit. No flag is set and `irq` stays low.
- R11: Force bits have no effect on the outputs while the one-pulse bit or the PWM bit is set.
- R12: Writing 1 to a STATUS bit clears that flag. `irq` is high exactly when an enabled flag is set, and compare flag 0 does not count while one-pulse mode is active.
- R13: A compare output reads 0 while its enable is 0. A match on a disabled channel does not change the level it shows once enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write address |
| reg_wdata | input | 16 | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 16 | Read data, combinational |
| ext_clk | input | 1 | External count clock, synchronised inside |
| cap_in | input | 2 | Capture pins, synchronised inside |
| cmp_out | output | 2 | Compare outputs |
| stat_flags | output | 4 | Status flags, same layout as STATUS |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler phase or count step shows up in the counter read-back and in the exact cycle a one-pulse output falls. That fall is predicted to the clock from the compare value and the divide, so an off-by-one tick moves the edge by N cycles. A wrong restart value or capture source shows up at once in the capture read-back after the three-cycle input synchroniser. A flag set from the wrong mode shows up on `stat_flags` and `irq` in the cycle after the event. Force and match priorities show up on `cmp_out` one cycle after the write or the counter step.

// File: rtl/ptim_pkg.sv
package ptim_pkg;

  localparam int unsigned N_CH   = 2;
  localparam int unsigned N_FLAG = 4;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned PRE_W  = 3;

  // register addresses
  localparam logic [REG_AW-1:0] A_CTL_A  = 3'd0;
  localparam logic [REG_AW-1:0] A_CTL_B  = 3'd1;
  localparam logic [REG_AW-1:0] A_STAT   = 3'd2;
  localparam logic [REG_AW-1:0] A_CMP0   = 3'd3;
  localparam logic [REG_AW-1:0] A_CAP0   = 3'd5;
  localparam logic [REG_AW-1:0] A_CNT    = 3'd7;

  // CTRL_A field positions
  localparam int unsigned CA_EDGE  = 0;
  localparam int unsigned CA_LVL   = 2;
  localparam int unsigned CA_FORCE = 4;
  localparam int unsigned CA_CAPIE = 6;
  localparam int unsigned CA_CMPIE = 7;

  // CTRL_B field positions
  localparam int unsigned CB_OE  = 0;
  localparam int unsigned CB_OPM = 2;
  localparam int unsigned CB_PWM = 3;
  localparam int unsigned CB_CLK = 4;

  // flag positions: capture i at i, compare i at F_CMP + i
  localparam int unsigned F_CAP = 0;
  localparam int unsigned F_CMP = 2;

  typedef enum logic [1:0] {
    CLK_DIV2 = 2'd0,
    CLK_DIV4 = 2'd1,
    CLK_DIV8 = 2'd2,
    CLK_EXT  = 2'd3
  } clk_sel_e;

  // prescale bits that must all be set for a divided tick
  function automatic logic [PRE_W-1:0] div_mask(input clk_sel_e sel);
    case (sel)
      CLK_DIV2: return 3'b001;
      CLK_DIV4: return 3'b011;
      CLK_DIV8: return 3'b111;
      default:  return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/ptim_edge_det.sv
module ptim_edge_det #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic edge_evt
);

  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              lvl_now;

  assign lvl_now  = sync_q[SYNC_N-1];
  assign edge_evt = rise_sel ? (lvl_now & ~prev_q) : (~lvl_now & prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], pin};
      prev_q <= lvl_now;
    end
  end

  // R3
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt && $stable(rise_sel) |=> !edge_evt);

endmodule

// File: rtl/ptim_prescaler.sv
module ptim_prescaler
  import ptim_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  clk_sel_e sel,
  input  logic     ext_clk,
  input  logic     restart,
  output logic     tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             div_hit;
  logic             ext_rise;

  assign mask    = div_mask(sel);
  assign div_hit = ((pre_q & mask) == mask);
  assign tick    = (sel == CLK_EXT) ? ext_rise : div_hit;

  ptim_edge_det #(.SYNC_N(2)) u_ext_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (ext_clk),
    .rise_sel (1'b1),
    .edge_evt (ext_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else              pre_q <= pre_q + PRE_W'(1);
  end

  // R2
  div_tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && sel != CLK_EXT |=> !(tick && sel != CLK_EXT));

endmodule

// File: rtl/ptim_counter.sv
module ptim_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);

  function automatic logic [CNT_W-1:0] restart_word();
    return {CNT_W{1'b1}} - CNT_W'(3);
  endfunction

  function automatic logic [CNT_W-1:0] step_word(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt_q;
  assign cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= restart_word();
    else if (tick)    cnt_q <= step_word(cnt_q);
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !restart |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !restart |=> $stable(cnt_q));

  // R5
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> &cnt_q[CNT_W-1:2] && cnt_q[1:0] == 2'b00);

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
  import ptim_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [CNT_W-1:0]  reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              ext_clk,
  input  logic [N_CH-1:0]   cap_in,
  output logic [N_CH-1:0]   cmp_out,
  output logic [N_FLAG-1:0] stat_flags,
  output logic              irq
);

  function automatic logic [CNT_W-1:0] opm_capture_word();
    return {CNT_W{1'b1}} - CNT_W'(2);
  endfunction

  function automatic logic [CNT_W-1:0] count_after_tick(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  // control state
  logic [N_CH-1:0]   edge_rise_q;
  logic [N_CH-1:0]   lvl_q;
  logic [N_CH-1:0]   oe_q;
  logic              cap_ie_q;
  logic              cmp_ie_q;
  logic              opm_q;
  logic              pwm_q;
  clk_sel_e          clk_sel_q;
  logic [N_FLAG-1:0] flags_q;
  logic [N_CH-1:0]   out_lvl_q;
  logic [CNT_W-1:0]  cmp_q [N_CH];
  logic [CNT_W-1:0]  cap_q [N_CH];
  logic [CNT_W-1:0]  cap_src [N_CH];
  logic [CNT_W-1:0]  cnt_q;

  // named internal events
  logic              wr_ctl_a;
  logic              wr_ctl_b;
  logic              wr_stat;
  logic              tick;
  logic              restart;
  logic              opm_act;
  logic              normal_mode;
  logic [N_CH-1:0]   edge_evt;
  logic [N_CH-1:0]   force_evt;
  logic [N_CH-1:0]   cmp_hit;
  logic [N_FLAG-1:0] flag_set;
  logic [N_FLAG-1:0] flag_clr;

  assign wr_ctl_a    = reg_we && (reg_waddr == A_CTL_A);
  assign wr_ctl_b    = reg_we && (reg_waddr == A_CTL_B);
  assign wr_stat     = reg_we && (reg_waddr == A_STAT);
  assign normal_mode = ~opm_q & ~pwm_q;
  assign opm_act     = opm_q & ~pwm_q;
  assign restart     = opm_act & edge_evt[0];

  ptim_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (clk_sel_q),
    .ext_clk (ext_clk),
    .restart (restart),
    .tick    (tick)
  );

  ptim_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .restart (restart),
    .cnt     (cnt_q)
  );

  assign cap_src[0] = restart ? opm_capture_word() : cnt_q;
  assign cap_src[1] = cnt_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    ptim_edge_det #(.SYNC_N(2)) u_cap_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (cap_in[g]),
      .rise_sel (edge_rise_q[g]),
      .edge_evt (edge_evt[g])
    );

    assign force_evt[g] = wr_ctl_a & reg_wdata[CA_FORCE+g] & normal_mode;
    assign cmp_hit[g]   = tick & ~restart & (count_after_tick(cnt_q) == cmp_q[g]);
    assign flag_set[F_CAP+g] = edge_evt[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q[g] <= '0;
        cap_q[g] <= '0;
      end else begin
        if (reg_we && reg_waddr == REG_AW'(A_CMP0 + g)) cmp_q[g] <= reg_wdata;
        if (edge_evt[g]) cap_q[g] <= cap_src[g];
      end
    end
  end

  assign flag_set[F_CMP+0] = cmp_hit[0] & ~opm_act;
  assign flag_set[F_CMP+1] = cmp_hit[1];
  assign flag_clr = wr_stat ? reg_wdata[N_FLAG-1:0] : '0;

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_rise_q <= '0;
      lvl_q       <= '0;
      cap_ie_q    <= 1'b0;
      cmp_ie_q    <= 1'b0;
      oe_q        <= '0;
      opm_q       <= 1'b0;
      pwm_q       <= 1'b0;
      clk_sel_q   <= CLK_DIV2;
    end else begin
      if (wr_ctl_a) begin
        edge_rise_q <= reg_wdata[CA_EDGE +: N_CH];
        lvl_q       <= reg_wdata[CA_LVL +: N_CH];
        cap_ie_q    <= reg_wdata[CA_CAPIE];
        cmp_ie_q    <= reg_wdata[CA_CMPIE];
      end
      if (wr_ctl_b) begin
        oe_q      <= reg_wdata[CB_OE +: N_CH];
        opm_q     <= reg_wdata[CB_OPM];
        pwm_q     <= reg_wdata[CB_PWM];
        clk_sel_q <= clk_sel_e'(reg_wdata[CB_CLK +: 2]);
      end
    end
  end

  // flags: a set in the same cycle wins over a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flag_set | (flags_q & ~flag_clr);
  end

  // output levels: restart, then match, then force
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_lvl_q <= '0;
    end else begin
      if (oe_q[0]) begin
        if (restart)                                out_lvl_q[0] <= lvl_q[1];
        else if (cmp_hit[0] & (opm_act | normal_mode)) out_lvl_q[0] <= lvl_q[0];
        else if (force_evt[0])                      out_lvl_q[0] <= reg_wdata[CA_LVL+0];
      end
      if (oe_q[1]) begin
        if (cmp_hit[1] & normal_mode) out_lvl_q[1] <= lvl_q[1];
        else if (force_evt[1])        out_lvl_q[1] <= reg_wdata[CA_LVL+1];
      end
    end
  end

  assign cmp_out    = out_lvl_q & oe_q;
  assign stat_flags = flags_q;
  assign irq = (cap_ie_q & (flags_q[F_CAP+0] | flags_q[F_CAP+1]))
             | (cmp_ie_q & ((flags_q[F_CMP+0] & ~opm_act) | flags_q[F_CMP+1]));

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      A_CTL_A: begin
        reg_rdata[CA_EDGE +: N_CH] = edge_rise_q;
        reg_rdata[CA_LVL +: N_CH]  = lvl_q;
        reg_rdata[CA_CAPIE]        = cap_ie_q;
        reg_rdata[CA_CMPIE]        = cmp_ie_q;
      end
      A_CTL_B: begin
        reg_rdata[CB_OE +: N_CH] = oe_q;
        reg_rdata[CB_OPM]        = opm_q;
        reg_rdata[CB_PWM]        = pwm_q;
        reg_rdata[CB_CLK +: 2]   = clk_sel_q;
      end
      A_STAT:     reg_rdata[N_FLAG-1:0] = flags_q;
      A_CMP0:     reg_rdata = cmp_q[0];
      A_CMP0 + 1: reg_rdata = cmp_q[1];
      A_CAP0:     reg_rdata = cap_q[0];
      A_CAP0 + 1: reg_rdata = cap_q[1];
      A_CNT:      reg_rdata = cnt_q;
      default:    reg_rdata = '0;
    endcase
  end

  // R5
  opm_restart_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> flags_q[F_CAP+0] && cap_q[0] == opm_capture_word());

  // R6
  opm_no_cmp0_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opm_act |=> !$rose(flags_q[F_CMP+0]));

  // R9
  pwm_plain_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_q && opm_q && edge_evt[0] |=> cap_q[0] == $past(cnt_q));

  // R10
  force_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|force_evt) && !(|cmp_hit) |=> flags_q[F_CMP +: N_CH] == $past(flags_q[F_CMP +: N_CH]));

endmodule

// File: tb/pulse_timer_bench.sv
`timescale 1ns/1ps
module pulse_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_waddr = '0;
  logic [15:0] reg_wdata = '0;
  logic [2:0]  reg_raddr = '0;
  logic [15:0] reg_rdata;
  logic        ext_clk = 1'b0;
  logic [1:0]  cap_in = '0;
  logic [1:0]  cmp_out;
  logic [3:0]  stat_flags;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;

  localparam logic [2:0] AD_CA = 0, AD_CB = 1, AD_ST = 2, AD_CMP0 = 3, AD_CMP1 = 4,
                         AD_CAP0 = 5, AD_CAP1 = 6, AD_CNT = 7;

  always #2.5 clk = ~clk;

  pulse_timer u_pulse_timer (
    .clk, .rst_n, .reg_we, .reg_waddr, .reg_wdata, .reg_raddr, .reg_rdata,
    .ext_clk, .cap_in, .cmp_out, .stat_flags, .irq
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    step(1);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    reg_raddr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic ext_pulse();
    ext_clk = 1'b1; step(4);
    ext_clk = 1'b0; step(4);
  endtask

  task automatic set_cap(input int ch, input logic v);
    cap_in[ch] = v;
    step(3);
  endtask

  // pulse length in system clocks, from the stated formula
  function automatic int pulse_len(input logic [15:0] cmp, input int div);
    logic [15:0] ticks;
    ticks = cmp - 16'hFFFC;
    return int'(ticks) * div;
  endfunction

  task automatic t_reset();
    logic [15:0] v;
    rd(AD_CNT, v);
    chk("R1", "count", v, 0);
    chk("R1", "cmp_out", cmp_out, 0);
    chk("R1", "flags", stat_flags, 0);
    chk("R1", "irq", irq, 0);
  endtask

  task automatic t_prescale();
    logic [15:0] c0, c1;
    for (int s = 0; s < 3; s++) begin
      int div = 2 << s;
      wr(AD_CB, 16'(s << 4));
      step(10);
      rd(AD_CNT, c0);
      step(8 * div);
      rd(AD_CNT, c1);
      chk("R2", $sformatf("steps over 8 periods, divide %0d", div), c1 - c0, 8);
    end
    wr(AD_CB, 16'h0030);
    step(4);
    rd(AD_CNT, c0);
    step(40);
    rd(AD_CNT, c1);
    chk("R2", "external clock idle holds", c1, c0);
    for (int k = 0; k < 5; k++) ext_pulse();
    rd(AD_CNT, c1);
    chk("R2", "five external edges", c1 - c0, 5);
  endtask

  task automatic t_capture();
    logic [15:0] c, v;
    wr(AD_CA, 16'h0001);              // ch0 rising, ch1 falling
    rd(AD_CNT, c);
    set_cap(0, 1'b1);
    chk("R3", "cap0 flag on rising", stat_flags[0], 1);
    rd(AD_CAP0, v);
    chk("R3", "cap0 value", v, c);
    set_cap(1, 1'b1);
    chk("R3", "cap1 ignores rising", stat_flags[1], 0);
    ext_pulse();
    set_cap(1, 1'b0);
    chk("R3", "cap1 flag on falling", stat_flags[1], 1);
    rd(AD_CAP1, v);
    chk("R3", "cap1 value", v, c + 16'd1);
    wr(AD_ST, 16'h000F);
    chk("R12", "flags cleared", stat_flags, 0);
    set_cap(0, 1'b0);
    chk("R3", "cap0 ignores falling", stat_flags[0], 0);
  endtask

  task automatic t_compare();
    logic [15:0] c;
    rd(AD_CNT, c);
    wr(AD_CMP0, c + 16'd2);
    wr(AD_CMP1, c + 16'd1);
    wr(AD_CB, 16'h0031);              // oe0 only, external clock
    wr(AD_CA, 16'h000C);              // L0 = L1 = 1
    ext_pulse();
    chk("R4", "cmp1 flag on match", stat_flags[3], 1);
    chk("R13", "disabled output reads 0", cmp_out[1], 0);
    chk("R4", "no cmp0 flag early", stat_flags[2], 0);
    chk("R4", "out0 still low", cmp_out[0], 0);
    ext_pulse();
    chk("R4", "cmp0 flag on match", stat_flags[2], 1);
    chk("R4", "out0 takes L0", cmp_out[0], 1);
    wr(AD_CB, 16'h0033);
    chk("R13", "out1 kept its level after enable", cmp_out[1], 0);
    wr(AD_ST, 16'h000F);
  endtask

  task automatic t_force();
    wr(AD_CA, 16'h00C0 | 16'h0030 | 16'h0008);   // both ie, force both, L0=0 L1=1
    chk("R10", "forced outputs", cmp_out, 2'b10);
    chk("R10", "no flags", stat_flags, 0);
    chk("R10", "no irq", irq, 0);
  endtask

  task automatic t_irq();
    logic [15:0] c;
    wr(AD_CA, 16'h0041);
    set_cap(0, 1'b1);
    chk("R12", "irq from enabled capture", irq, 1);
    wr(AD_ST, 16'h0001);
    chk("R12", "W1C clears cap0", stat_flags[0], 0);
    chk("R12", "irq drops", irq, 0);
    wr(AD_CA, 16'h0001);
    set_cap(0, 1'b0);
    set_cap(0, 1'b1);
    chk("R12", "flag set with ie off", stat_flags[0], 1);
    chk("R12", "no irq when disabled", irq, 0);
    wr(AD_ST, 16'h000F);
    rd(AD_CNT, c);
    wr(AD_CMP0, c + 16'd1);
    wr(AD_CA, 16'h0081);
    ext_pulse();
    chk("R12", "irq from cmp0", irq, 1);
    wr(AD_CB, 16'h0037);              // one-pulse on, still external clock
    chk("R12", "cmp0 flag kept", stat_flags[2], 1);
    chk("R12", "cmp0 ignored in one-pulse", irq, 0);
    wr(AD_CB, 16'h0033);
    wr(AD_ST, 16'h000F);
  endtask

  task automatic t_opm();
    logic [15:0] v;
    logic o1;
    int w;
    set_cap(0, 1'b0);
    wr(AD_CMP0, 16'h0004);
    wr(AD_CMP1, 16'h0002);
    wr(AD_CA, 16'h0009);              // rise ch0, after L0=0, during L1=1
    wr(AD_CB, 16'h0007);              // oe both, one-pulse, divide 2
    wr(AD_ST, 16'h000F);
    o1 = cmp_out[1];
    w = pulse_len(16'h0004, 2);
    set_cap(0, 1'b1);
    chk("R5", "during level", cmp_out[0], 1);
    chk("R5", "cap0 flag", stat_flags[0], 1);
    rd(AD_CAP0, v);
    chk("R5", "cap0 value", v, 16'hFFFD);
    rd(AD_CNT, v);
    chk("R5", "counter restart", v, 16'hFFFC);
    step(w - 1);
    chk("R6", "still in pulse", cmp_out[0], 1);
    step(1);
    chk("R6", "after level at width", cmp_out[0], 0);
    chk("R6", "no cmp0 flag", stat_flags[2], 0);
    chk("R7", "cmp1 flag set", stat_flags[3], 1);
    chk("R7", "out1 unchanged", cmp_out[1], o1);
    // second pulse, divide 4
    wr(AD_CB, 16'h0017);
    wr(AD_CMP0, 16'h0001);
    set_cap(0, 1'b0);
    w = pulse_len(16'h0001, 4);
    set_cap(0, 1'b1);
    chk("R5", "during level, divide 4", cmp_out[0], 1);
    step(w - 1);
    chk("R6", "still in pulse, divide 4", cmp_out[0], 1);
    step(1);
    chk("R6", "after level, divide 4", cmp_out[0], 0);
    wr(AD_CA, 16'h001D);              // force ch0 with L0=1
    chk("R11", "force ignored in one-pulse", cmp_out[0], 0);
  endtask

  task automatic t_opm_equal();
    set_cap(0, 1'b0);
    wr(AD_CA, 16'h0001);              // L0 = L1 = 0
    wr(AD_ST, 16'h000F);
    set_cap(0, 1'b1);
    chk("R8", "edge seen", stat_flags[0], 1);
    chk("R8", "no pulse at restart", cmp_out[0], 0);
    step(40);
    chk("R8", "no pulse after match", cmp_out[0], 0);
  endtask

  task automatic t_pwm();
    logic [15:0] c, v;
    wr(AD_CB, 16'h003F);              // pwm + one-pulse, external clock
    wr(AD_CA, 16'h0009);
    set_cap(0, 1'b0);
    rd(AD_CNT, c);
    set_cap(0, 1'b1);
    rd(AD_CNT, v);
    chk("R9", "no restart", v, c);
    rd(AD_CAP0, v);
    chk("R9", "plain capture", v, c);
    chk("R9", "out0 not driven", cmp_out[0], 0);
    wr(AD_CA, 16'h001D);
    chk("R11", "force ignored in PWM", cmp_out[0], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_prescale();
    t_capture();
    t_compare();
    t_force();
    t_irq();
    t_opm();
    t_opm_equal();
    t_pwm();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule